// File: doc/BRIEF.md
# Paged Packet Buffer Byte Window

This block lets a host bus reach packet storage one byte at a time. The storage is split into fixed-size pages of 2048 bytes, four pages by default. A 16-bit address register selects the byte. Its low eleven bits hold the byte offset inside a page. Two flag bits in its upper byte choose which page is accessed and whether the offset advances on its own.

The page can come from either of two inputs, both supplied by the surrounding allocation logic. One is the page at the head of the receive queue. The other is the page the host has named for its own use. Four consecutive bus addresses form the data window. Without auto-advance, the window address adds a lane offset of 0 to 3. With auto-advance, every data access uses the stored offset and then steps it by one. The host loads the address register a byte at a time.

Top module: `pdp_data_port`

## Requirements
- R1: While reset is asserted and right after it, the address register is 0x0000, so both of its bytes read back as 0x00.
- R2: A write to bus address 4 loads address-register bits 7:0, and a write to bus address 5 loads bits 15:8. A read of address 4 returns bits 7:0. A read of address 5 returns bits 15:8 with bit 3 of that byte (register bit 11) forced to 0, i.e. masked with 0xF7.
- R3: When register bit 15 is 1, data accesses use the page on `rx_head_page`. When it is 0, they use the page on `host_page`. The choice follows the inputs as they are in the access cycle.
- R4: When register bit 14 is 0, a data access at bus address L (L in 0..3) reaches byte (offset + L) mod 2048 of the selected page. The address register does not change.
- R5: When register bit 14 is 1, a data access reaches the byte at the stored offset, whatever the lane L is. The offset then increases by one.
- R6: Auto-advance from offset 0x7FF gives offset 0x000. Register bits 15:11 keep their value.
- R7: A data read returns the stored byte in the same cycle, before any advance. The advanced offset is visible from the next clock cycle.
- R8: A data write followed by a data read that resolves to the same page and byte returns the written value. Reads and writes follow the same address rules.
- R9: With `bus_cs` low, a write changes neither the address register nor the storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_cs | input | 1 | Access strobe, one byte per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | 0..3 data lanes, 4 address register low byte, 5 address register high byte |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, combinational |
| rx_head_page | input | PAGE_W (2) | Page at the head of the receive queue |
| host_page | input | PAGE_W (2) | Page chosen by the host |

## Verification
Read data is combinational. The bench drives every access on the falling clock edge and checks `bus_rdata` one nanosecond later, inside the same cycle. Storage writes and address-register updates, including the auto-advance, land on the next rising edge. Each vector's effect is therefore checked by the read in a later vector, never by the access that caused it. A reset assertion clears the address register at once, without waiting for the clock, so that check samples right after `rst_n` falls. After release, the bench waits three rising edges for the two-flop synchronizer before it drives anything.

// File: rtl/pdp_pkg.sv
package pdp_pkg;

  localparam int PTR_W       = 16;
  localparam int RXSEL_BIT   = 15;
  localparam int AINC_BIT    = 14;
  localparam int LANES       = 4;
  localparam logic [7:0] HI_RD_MASK = 8'hF7;

  typedef enum logic [2:0] {
    SEL_LANE0  = 3'd0,
    SEL_LANE1  = 3'd1,
    SEL_LANE2  = 3'd2,
    SEL_LANE3  = 3'd3,
    SEL_PTR_LO = 3'd4,
    SEL_PTR_HI = 3'd5,
    SEL_RSV6   = 3'd6,
    SEL_RSV7   = 3'd7
  } win_sel_e;

  typedef struct packed {
    logic data_rd;
    logic data_wr;
    logic ptr_lo_wr;
    logic ptr_hi_wr;
  } acc_t;

endpackage

// File: rtl/pdp_rst_sync.sv
module pdp_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/pdp_ptr_reg.sv
module pdp_ptr_reg
  import pdp_pkg::*;
#(
  parameter int OFS_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lo_we,
  input  logic             hi_we,
  input  logic             step,
  input  logic [7:0]       wdata,
  output logic [PTR_W-1:0] ptr_q
);

  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;
  logic [OFS_W-1:0] ofs_inc;

  // offset increment wraps inside the offset field; upper bits untouched
  assign ofs_inc = ptr_q[OFS_W-1:0] + {{(OFS_W-1){1'b0}}, 1'b1};
  assign ptr_en  = lo_we | hi_we | step;

  always_comb begin
    ptr_d = ptr_q;
    if (hi_we) ptr_d[15:8] = wdata;
    if (lo_we) ptr_d[7:0]  = wdata;
    else if (step) ptr_d[OFS_W-1:0] = ofs_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

endmodule

// File: rtl/pdp_addr_gen.sv
module pdp_addr_gen #(
  parameter int OFS_W  = 11,
  parameter int PAGE_W = 2
) (
  input  logic              rx_sel,
  input  logic              ainc,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [1:0]        lane,
  input  logic [PAGE_W-1:0] rx_head_page,
  input  logic [PAGE_W-1:0] host_page,
  output logic [PAGE_W-1:0] page,
  output logic [OFS_W-1:0]  byte_ofs
);

  logic [OFS_W-1:0] lane_add;

  // lane offset only applies without auto-advance; sum wraps inside the page
  assign lane_add = ainc ? '0 : {{(OFS_W-2){1'b0}}, lane};
  assign byte_ofs = ofs + lane_add;
  assign page     = rx_sel ? rx_head_page : host_page;

endmodule

// File: rtl/pdp_page_ram.sv
module pdp_page_ram
  import pdp_pkg::*;
#(
  parameter int N_PAGES = 4,
  parameter int OFS_W   = 11,
  localparam int PAGE_W = $clog2(N_PAGES),
  localparam int WORD_W = OFS_W - 2,
  localparam int IDX_W  = PAGE_W + WORD_W,
  localparam int DEPTH  = N_PAGES << WORD_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PAGE_W-1:0] page,
  input  logic [OFS_W-1:0]  byte_ofs,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);

  logic [IDX_W-1:0] idx;
  logic [1:0]       lane;
  logic [7:0]       lane_rd [LANES];

  assign idx  = {page, byte_ofs[OFS_W-1:2]};
  assign lane = byte_ofs[1:0];

  // one byte-wide bank per lane keeps each array at DEPTH entries
  for (genvar g = 0; g < LANES; g++) begin : g_bank
    logic [7:0] bank [DEPTH];
    logic       bank_we;

    assign bank_we = we && (lane == 2'(g));

    always_ff @(posedge clk) begin
      if (bank_we) bank[idx] <= wdata;
    end

    assign lane_rd[g] = bank[idx];
  end

  assign rdata = lane_rd[lane];

endmodule

// File: rtl/pdp_data_port.sv
module pdp_data_port
  import pdp_pkg::*;
#(
  parameter int N_PAGES = 4,
  parameter int OFS_W   = 11,
  localparam int PAGE_W = $clog2(N_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [PAGE_W-1:0] rx_head_page,
  input  logic [PAGE_W-1:0] host_page
);

  logic             rst_sync_n;
  win_sel_e         sel;
  acc_t             acc;
  logic             step;
  logic [PTR_W-1:0] ptr_q;
  logic [PAGE_W-1:0] page;
  logic [OFS_W-1:0] byte_ofs;
  logic [7:0]       ram_rd;

  pdp_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  assign sel = win_sel_e'(bus_addr);

  always_comb begin
    acc = '0;
    if (bus_cs) begin
      unique case (sel)
        SEL_LANE0, SEL_LANE1, SEL_LANE2, SEL_LANE3: begin
          acc.data_wr = bus_we;
          acc.data_rd = !bus_we;
        end
        SEL_PTR_LO: acc.ptr_lo_wr = bus_we;
        SEL_PTR_HI: acc.ptr_hi_wr = bus_we;
        default: acc = '0;
      endcase
    end
  end

  assign step = (acc.data_rd | acc.data_wr) & ptr_q[AINC_BIT];

  pdp_ptr_reg #(.OFS_W(OFS_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .lo_we (acc.ptr_lo_wr),
    .hi_we (acc.ptr_hi_wr),
    .step  (step),
    .wdata (bus_wdata),
    .ptr_q (ptr_q)
  );

  pdp_addr_gen #(.OFS_W(OFS_W), .PAGE_W(PAGE_W)) u_addr (
    .rx_sel       (ptr_q[RXSEL_BIT]),
    .ainc         (ptr_q[AINC_BIT]),
    .ofs          (ptr_q[OFS_W-1:0]),
    .lane         (bus_addr[1:0]),
    .rx_head_page (rx_head_page),
    .host_page    (host_page),
    .page         (page),
    .byte_ofs     (byte_ofs)
  );

  pdp_page_ram #(.N_PAGES(N_PAGES), .OFS_W(OFS_W)) u_ram (
    .clk      (clk),
    .we       (acc.data_wr),
    .page     (page),
    .byte_ofs (byte_ofs),
    .wdata    (bus_wdata),
    .rdata    (ram_rd)
  );

  always_comb begin
    unique case (sel)
      SEL_LANE0, SEL_LANE1, SEL_LANE2, SEL_LANE3: bus_rdata = ram_rd;
      SEL_PTR_LO: bus_rdata = ptr_q[7:0];
      SEL_PTR_HI: bus_rdata = ptr_q[15:8] & HI_RD_MASK;
      default:    bus_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/pdp_data_port_chk.sv
module pdp_data_port_chk #(
  parameter int OFS_W = 11
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_cs,
  input logic        bus_we,
  input logic [2:0]  bus_addr,
  input logic [7:0]  bus_rdata,
  input logic [15:0] ptr_q
);

  logic data_acc;
  assign data_acc = bus_cs && !bus_addr[2];

  // R2: high byte read always shows register bit 11 as zero
  a_r2_hi_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && !bus_we && bus_addr == 3'd5) |-> (bus_rdata[3] == 1'b0));

  // R4: without auto-advance a data access leaves the register alone
  a_r4_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !ptr_q[14]) |=> (ptr_q == $past(ptr_q)));

  // R5: with auto-advance the offset moves by exactly one
  a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && ptr_q[14]) |=>
      (ptr_q[OFS_W-1:0] == OFS_W'($past(ptr_q[OFS_W-1:0]) + 1'b1)));

  // R6: advance keeps the flag and upper bits
  a_r6_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && ptr_q[14]) |=> (ptr_q[15:11] == $past(ptr_q[15:11])));

  // R9: no strobe, no register change
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs) |=> $stable(ptr_q));

endmodule

bind pdp_data_port pdp_data_port_chk #(.OFS_W(OFS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_cs    (bus_cs),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .ptr_q     (ptr_q)
);

// File: tb/pdp_data_port_bench.sv
module pdp_data_port_bench;

  typedef struct packed {
    logic       cs;
    logic       we;
    logic [2:0] adr;
    logic [7:0] dat;
    logic [1:0] hp;
    logic [1:0] rp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 44;
  // reads (cs=1, we=0) check bus_rdata against dat in the same cycle
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b1,3'd4,8'h10,2'd1,2'd2,4'd2},  // R2 low byte
    '{1'b1,1'b1,3'd5,8'h00,2'd1,2'd2,4'd2},  // R2 high byte
    '{1'b1,1'b1,3'd0,8'hA0,2'd1,2'd2,4'd8},  // R8 lane writes
    '{1'b1,1'b1,3'd1,8'hA1,2'd1,2'd2,4'd8},
    '{1'b1,1'b1,3'd2,8'hA2,2'd1,2'd2,4'd8},
    '{1'b1,1'b1,3'd3,8'hA3,2'd1,2'd2,4'd8},
    '{1'b1,1'b0,3'd2,8'hA2,2'd1,2'd2,4'd4},  // R4 offset+lane
    '{1'b1,1'b0,3'd1,8'hA1,2'd1,2'd2,4'd4},
    '{1'b1,1'b0,3'd4,8'h10,2'd1,2'd2,4'd4},  // R4 register unchanged
    '{1'b1,1'b1,3'd5,8'h80,2'd1,2'd2,4'd3},  // R3 receive page
    '{1'b1,1'b1,3'd0,8'hB0,2'd1,2'd2,4'd3},
    '{1'b1,1'b0,3'd0,8'hB0,2'd1,2'd2,4'd3},
    '{1'b1,1'b1,3'd5,8'h00,2'd1,2'd2,4'd3},
    '{1'b1,1'b0,3'd0,8'hA0,2'd1,2'd2,4'd3},  // R3 host page untouched
    '{1'b1,1'b1,3'd5,8'h80,2'd1,2'd2,4'd3},
    '{1'b1,1'b0,3'd0,8'hB0,2'd1,2'd2,4'd3},
    '{1'b1,1'b0,3'd0,8'hA0,2'd1,2'd1,4'd3},  // R3 follows input
    '{1'b1,1'b1,3'd5,8'h40,2'd1,2'd2,4'd5},  // R5 auto-advance on
    '{1'b1,1'b1,3'd4,8'h20,2'd1,2'd2,4'd5},
    '{1'b1,1'b1,3'd3,8'hC0,2'd1,2'd2,4'd5},  // lane ignored
    '{1'b1,1'b1,3'd0,8'hC1,2'd1,2'd2,4'd5},
    '{1'b1,1'b0,3'd4,8'h22,2'd1,2'd2,4'd5},  // R5 two steps
    '{1'b1,1'b1,3'd4,8'h20,2'd1,2'd2,4'd7},
    '{1'b1,1'b0,3'd2,8'hC0,2'd1,2'd2,4'd7},  // R7 pre-advance byte
    '{1'b1,1'b0,3'd2,8'hC1,2'd1,2'd2,4'd7},
    '{1'b1,1'b0,3'd4,8'h22,2'd1,2'd2,4'd7},  // R7 reads advance too
    '{1'b1,1'b1,3'd5,8'h7F,2'd1,2'd2,4'd6},  // R6 offset 0x7FF
    '{1'b1,1'b1,3'd4,8'hFF,2'd1,2'd2,4'd6},
    '{1'b1,1'b1,3'd0,8'hD0,2'd1,2'd2,4'd6},
    '{1'b1,1'b0,3'd4,8'h00,2'd1,2'd2,4'd6},  // R6 wrapped to 0
    '{1'b1,1'b0,3'd5,8'h70,2'd1,2'd2,4'd6},  // R6 upper bits kept
    '{1'b1,1'b1,3'd5,8'h07,2'd1,2'd2,4'd4},
    '{1'b1,1'b1,3'd4,8'hFE,2'd1,2'd2,4'd4},
    '{1'b1,1'b0,3'd1,8'hD0,2'd1,2'd2,4'd4},  // R4 0x7FE+1
    '{1'b1,1'b1,3'd3,8'hE1,2'd1,2'd2,4'd4},  // R4 0x7FE+3 wraps to 0x001
    '{1'b1,1'b1,3'd5,8'h00,2'd1,2'd2,4'd4},
    '{1'b1,1'b1,3'd4,8'h00,2'd1,2'd2,4'd4},
    '{1'b1,1'b0,3'd1,8'hE1,2'd1,2'd2,4'd4},
    '{1'b0,1'b1,3'd4,8'h55,2'd1,2'd2,4'd9},  // R9 no strobe
    '{1'b0,1'b1,3'd1,8'h99,2'd1,2'd2,4'd9},
    '{1'b1,1'b0,3'd4,8'h00,2'd1,2'd2,4'd9},
    '{1'b1,1'b0,3'd1,8'hE1,2'd1,2'd2,4'd9},
    '{1'b1,1'b1,3'd5,8'h0F,2'd1,2'd2,4'd2},
    '{1'b1,1'b0,3'd5,8'h07,2'd1,2'd2,4'd2}   // R2 mask 0xF7
  };

  logic       clk;
  logic       rst_n;
  logic       bus_cs;
  logic       bus_we;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [1:0] rx_head_page;
  logic [1:0] host_page;

  int  n_tests;
  int  n_fail;
  bit  done;

  pdp_data_port u_pdp_data_port (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_cs       (bus_cs),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .rx_head_page (rx_head_page),
    .host_page    (host_page)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input logic [7:0] act, input logic [7:0] exp,
                       input int req, input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic rd_check(input logic [2:0] a, input logic [7:0] exp,
                          input int req, input string what);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 check(bus_rdata, exp, req, what);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    n_tests = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; bus_cs = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_wdata = '0; rx_head_page = 2'd2; host_page = 2'd1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: register clear after reset
    rd_check(3'd4, 8'h00, 1, "reset low byte");
    rd_check(3'd5, 8'h00, 1, "reset high byte");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bus_cs = TBL[i].cs; bus_we = TBL[i].we; bus_addr = TBL[i].adr;
      bus_wdata = TBL[i].dat; host_page = TBL[i].hp; rx_head_page = TBL[i].rp;
      #1;
      if (TBL[i].cs && !TBL[i].we)
        check(bus_rdata, TBL[i].dat, int'(TBL[i].req), $sformatf("vector %0d", i));
    end

    // R1: mid-run reset clears the register without a clock edge
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b0; bus_addr = 3'd5;
    rst_n = 1'b0;
    #1 check(bus_rdata, 8'h00, 1, "async clear high byte");
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    rd_check(3'd4, 8'h00, 1, "after reset low byte");

    // R8: storage survives reset; page 1 byte 0x7FF still readable
    @(negedge clk); bus_cs = 1'b1; bus_we = 1'b1; bus_addr = 3'd5; bus_wdata = 8'h07;
    @(negedge clk); bus_addr = 3'd4; bus_wdata = 8'hFC;
    rd_check(3'd3, 8'hD0, 8, "lane 3 at 0x7FC");

    @(negedge clk); bus_cs = 1'b0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule